// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of an 8-bit general-purpose I/O port. A serial bus front end, which is not part of this block, decodes transactions into a command code, a single-cycle write strobe with a data byte, and a strobe that marks the acknowledge of the command byte. The bank holds three writable registers:

- the output level register,
- the input-inversion mask,
- the pin direction register.

It also offers a read-only view of the pins and a latched snapshot of a separate 8-bit auxiliary input bus. Per pin, it drives an output value and an output enable. Pads, tri-state buffers and the bus protocol sit outside.

Reads are combinational from the current command code, so the front end can shift out read data as soon as the command is known. Pin inputs pass through a synchronizer before they are inverted and read. A dedicated active-low pin, held low long enough, returns every register to its power-up value without touching the system reset.

Top module: `gpio_regbank`

## Requirements
- R1: After system reset, the direction register is all ones, the output and inversion registers are all zeros, and the auxiliary snapshot is zero. So `pin_oe` is 0 and `pin_out` is 0 on every bit.
- R2: Writing command code 3 sets the direction register on the next clock edge. A 1 in bit n makes pin n an input with `pin_oe[n]` low. A 0 makes it an output with `pin_oe[n]` high.
- R3: Writing command code 1 sets the output register. `pin_out[n]` follows that register only while pin n is an output. A pin configured as an input drives `pin_out[n]` = 0, whatever its output bit holds.
- R4: Reading command code 1 returns the stored output register, independent of direction and of the level on `pin_in`. Reading code 2 returns the inversion register, and reading code 3 returns the direction register.
- R5: Reading command code 0 returns, for each bit, the synchronized pin value XOR (inversion bit AND direction bit). So inversion applies only to pins configured as inputs.
- R6: A change on `pin_in` appears in the code-0 read after `SYNC_STAGES` (default 2) rising clock edges, and not before.
- R7: When `cmd_ack` is high while the command code is 4, `aux_in` is captured on that clock edge. A read of code 4 returns the captured byte, and later changes on `aux_in` do not alter it.
- R8: When `hold_rst_n` is sampled low on `HOLD_CYCLES` consecutive rising edges, all registers return to their R1 values on the following edge. This includes the auxiliary snapshot.
- R9: Within one low interval of `hold_rst_n`, the default restore happens once. Writes made later in the same low interval persist.
- R10: A low pulse on `hold_rst_n` that lasts `HOLD_CYCLES-1` sampled edges or fewer changes no register.
- R11: Writes to codes 0, 4, 5, 6 and 7 change no register. Reads of codes 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_code | input | 3 | Selected register: 0 input view, 1 output, 2 inversion, 3 direction, 4 auxiliary snapshot |
| cmd_ack | input | 1 | Command-byte acknowledge strobe; captures aux_in when the code is 4 |
| wr_en | input | 1 | Single-cycle write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the selected register |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables, high drives the pin |
| aux_in | input | 8 | Auxiliary input bus |
| hold_rst_n | input | 1 | Timed active-low register-default request |

## Verification
The situation that is hardest to reach from the ports is a register write that lands while `hold_rst_n` is still held low after the restore has already fired. A correct design keeps that write; a design that re-arms the timer would wipe it.

The stimulus holds the pin low for several cycles beyond the threshold, writes the output and direction registers during that tail, and waits further cycles before releasing the pin. It then reads the registers back. A separate scenario releases the pin exactly one sample short of the threshold, which pins the comparison boundary from below.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int CMD_W = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_INPUT  = 3'd0,
      CMD_OUTPUT = 3'd1,
      CMD_INVERT = 3'd2,
      CMD_DIR    = 3'd3,
      CMD_AUX    = 3'd4
   } cmd_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_hold_timer.sv
module gpio_hold_timer #(
   parameter int HOLD_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   output logic clr
);
   generate
      if (HOLD_CYCLES < 2) begin : g_bad
         $error("gpio_hold_timer: HOLD_CYCLES must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] cnt;
   logic          fired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fired <= 1'b0;
         clr   <= 1'b0;
      end else begin
         clr <= 1'b0;
         if (req_n) begin
            cnt   <= '0;
            fired <= 1'b0;
         end else if (!fired) begin
            if (cnt == LAST) begin
               clr   <= 1'b1;
               fired <= 1'b1;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pkg::*;
#(
   parameter int          W           = 8,
   parameter logic [W-1:0] OUT_RESET  = '0,
   parameter logic [W-1:0] INV_RESET  = '0,
   parameter logic [W-1:0] DIR_RESET  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CMD_W-1:0] cmd,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             cmd_ack,
   input  logic [W-1:0]     aux_in,
   input  logic [W-1:0]     in_sync,
   output logic [W-1:0]     out_q,
   output logic [W-1:0]     inv_q,
   output logic [W-1:0]     dir_q,
   output logic [W-1:0]     aux_q,
   output logic [W-1:0]     rd_data
);
   logic wr_out, wr_inv, wr_dir, cap_aux;

   assign wr_out  = wr_en && (cmd == CMD_OUTPUT);
   assign wr_inv  = wr_en && (cmd == CMD_INVERT);
   assign wr_dir  = wr_en && (cmd == CMD_DIR);
   assign cap_aux = cmd_ack && (cmd == CMD_AUX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= OUT_RESET;
         inv_q <= INV_RESET;
         dir_q <= DIR_RESET;
         aux_q <= '0;
      end else if (clr) begin
         out_q <= OUT_RESET;
         inv_q <= INV_RESET;
         dir_q <= DIR_RESET;
         aux_q <= '0;
      end else begin
         if (wr_out)  out_q <= wr_data;
         if (wr_inv)  inv_q <= wr_data;
         if (wr_dir)  dir_q <= wr_data;
         if (cap_aux) aux_q <= aux_in;
      end
   end

   logic [W-1:0] in_view;
   assign in_view = in_sync ^ (inv_q & dir_q);

   always_comb begin
      case (cmd)
         CMD_INPUT:  rd_data = in_view;
         CMD_OUTPUT: rd_data = out_q;
         CMD_INVERT: rd_data = inv_q;
         CMD_DIR:    rd_data = dir_q;
         CMD_AUX:    rd_data = aux_q;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_code,
   input  logic             cmd_ack,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   output logic [W-1:0]     rd_data,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pin_out,
   output logic [W-1:0]     pin_oe,
   input  logic [W-1:0]     aux_in,
   input  logic             hold_rst_n
);
   generate
      if (W < 1 || W > 32) begin : g_bad_w
         $error("gpio_regbank: W out of range");
      end
   endgenerate

   logic         clr;
   logic [W-1:0] in_sync, out_q, inv_q, dir_q, aux_q;

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
   );

   gpio_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .req_n(hold_rst_n), .clr(clr)
   );

   gpio_regfile #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd_code),
      .wr_en(wr_en), .wr_data(wr_data), .cmd_ack(cmd_ack),
      .aux_in(aux_in), .in_sync(in_sync),
      .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q), .aux_q(aux_q),
      .rd_data(rd_data)
   );

   generate
      for (genvar n = 0; n < W; n++) begin : g_pin
         assign pin_oe[n]  = ~dir_q[n];
         assign pin_out[n] = dir_q[n] ? 1'b0 : out_q[n];
      end
   endgenerate
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
   import gpio_pkg::*;
#(
   parameter int W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CMD_W-1:0] cmd_code,
   input logic             cmd_ack,
   input logic             wr_en,
   input logic [W-1:0]     wr_data,
   input logic [W-1:0]     pin_out,
   input logic [W-1:0]     pin_oe,
   input logic [W-1:0]     aux_q,
   input logic             clr
);
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd_code == CMD_DIR && !clr) |=> (pin_oe == ~$past(wr_data))); // R2

   AST_INPUT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0)); // R3

   AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd_code == CMD_OUTPUT && !clr) |=> (pin_out == ($past(wr_data) & pin_oe))); // R3

   AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cmd_ack && cmd_code == CMD_AUX) && !clr) |=> $stable(aux_q)); // R7

   AST_CLR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pin_oe == '0 && pin_out == '0 && aux_q == '0)); // R8

   AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && (cmd_code == CMD_INPUT || cmd_code > CMD_DIR))
         |=> ($stable(pin_oe) && $stable(pin_out))); // R11
endmodule

bind gpio_regbank gpio_regbank_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_ack(cmd_ack),
   .wr_en(wr_en), .wr_data(wr_data), .pin_out(pin_out), .pin_oe(pin_oe),
   .aux_q(aux_q), .clr(clr)
);

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd_code = '0;
   logic       cmd_ack = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;
   logic [7:0] aux_in = '0;
   logic       hold_rst_n = 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_regbank #(.W(8), .SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_ack(cmd_ack),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .aux_in(aux_in), .hold_rst_n(hold_rst_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cycles(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] c, input logic [7:0] d);
      cmd_code = c; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] c, output logic [7:0] d);
      cmd_code = c;
      #1 d = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 oe", pin_oe, 8'h00);
      check("R1 out", pin_out, 8'h00);
      rd(3'd3, v); check("R1 dir", v, 8'hFF);
      rd(3'd1, v); check("R1 outreg", v, 8'h00);
      rd(3'd2, v); check("R1 inv", v, 8'h00);
      rd(3'd4, v); check("R1 aux", v, 8'h00);
   endtask

   task automatic t_direction();
      wr(3'd3, 8'h0F);
      check("R2 oe", pin_oe, 8'hF0);
      wr(3'd3, 8'hA5);
      check("R2 oe2", pin_oe, 8'h5A);
   endtask

   task automatic t_output();
      wr(3'd1, 8'hFF);
      check("R3 gated", pin_out, 8'h5A);
      wr(3'd3, 8'h00);
      check("R3 all out", pin_out, 8'hFF);
      wr(3'd1, 8'h3C);
      check("R3 value", pin_out, 8'h3C);
   endtask

   task automatic t_readback();
      logic [7:0] v;
      wr(3'd3, 8'hFF);
      pin_in = 8'h00;
      cycles(3);
      rd(3'd1, v); check("R4 stored", v, 8'h3C);
      check("R4 pin gated", pin_out, 8'h00);
      wr(3'd2, 8'h81);
      rd(3'd2, v); check("R4 inv read", v, 8'h81);
   endtask

   task automatic t_polarity();
      logic [7:0] v;
      wr(3'd2, 8'hFF);
      wr(3'd3, 8'h0F);
      pin_in = 8'h33;
      cycles(3);
      rd(3'd0, v); check("R5 mixed", v, 8'h33 ^ 8'h0F);
      wr(3'd2, 8'h00);
      rd(3'd0, v); check("R5 none", v, 8'h33);
      wr(3'd3, 8'hFF);
   endtask

   task automatic t_sync();
      logic [7:0] v;
      pin_in = 8'h00;
      cycles(3);
      pin_in = 8'hC6;
      cmd_code = 3'd0;
      @(negedge clk);
      rd(3'd0, v); check("R6 one edge", v, 8'h00);
      @(negedge clk);
      rd(3'd0, v); check("R6 two edges", v, 8'hC6);
   endtask

   task automatic t_aux();
      logic [7:0] v;
      aux_in = 8'h5E;
      cmd_code = 3'd4; cmd_ack = 1'b1;
      @(negedge clk);
      cmd_ack = 1'b0;
      aux_in = 8'h11;
      cycles(2);
      rd(3'd4, v); check("R7 latched", v, 8'h5E);
      cmd_code = 3'd1; cmd_ack = 1'b1;
      @(negedge clk);
      cmd_ack = 1'b0;
      rd(3'd4, v); check("R7 other code", v, 8'h5E);
   endtask

   task automatic t_ignored();
      logic [7:0] v;
      wr(3'd1, 8'h77);
      wr(3'd2, 8'h0C);
      wr(3'd3, 8'h0F);
      for (int c = 0; c < 8; c++) begin
         if (c == 0 || c > 3) wr(3'(c), 8'hE9);
      end
      rd(3'd1, v); check("R11 out", v, 8'h77);
      rd(3'd2, v); check("R11 inv", v, 8'h0C);
      rd(3'd3, v); check("R11 dir", v, 8'h0F);
      rd(3'd4, v); check("R11 aux", v, 8'h5E);
      rd(3'd6, v); check("R11 read 6", v, 8'h00);
   endtask

   task automatic t_short_pulse();
      logic [7:0] v;
      hold_rst_n = 1'b0;
      cycles(HOLD - 1);
      hold_rst_n = 1'b1;
      cycles(3);
      rd(3'd1, v); check("R10 out", v, 8'h77);
      check("R10 oe", pin_oe, 8'hF0);
   endtask

   task automatic t_hold_reset();
      logic [7:0] v;
      hold_rst_n = 1'b0;
      cycles(HOLD + 1);
      check("R8 oe", pin_oe, 8'h00);
      rd(3'd1, v); check("R8 out", v, 8'h00);
      rd(3'd2, v); check("R8 inv", v, 8'h00);
      rd(3'd4, v); check("R8 aux", v, 8'h00);
      wr(3'd1, 8'hA0);
      wr(3'd3, 8'h3F);
      cycles(2 * HOLD);
      rd(3'd1, v); check("R9 out kept", v, 8'hA0);
      check("R9 pins", pin_out, 8'h80);
      hold_rst_n = 1'b1;
      cycles(2);
      check("R9 oe kept", pin_oe, 8'hC0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_direction();
      t_output();
      t_readback();
      t_polarity();
      t_sync();
      t_aux();
      t_ignored();
      t_short_pulse();
      t_hold_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule